// File: doc/BRIEF.md
# Single-Precision Floating-Point Square Root

This block takes one binary32 operand through a valid/ready request and returns its square root, also in binary32, on a one-cycle result strobe. The operand is split into sign, biased exponent and fraction. The significand gets back its hidden leading one. When the unbiased exponent is odd, the significand is doubled and the exponent is lowered by one, so that halving the exponent is exact. The widened significand then goes through a non-restoring integer square root that produces one root bit per clock. The root is packed with the halved exponent.

The unit handles one operation at a time. It drops request ready when it accepts an operand and raises it again after the result cycle. Every operand takes the same number of cycles, special encodings included, so a caller can count on a fixed latency. Root bits below the 23-bit fraction are dropped, which means the result is truncated toward zero and never rounded. Subnormal operands are treated as zero.

Top module: `fp32_sqrt_unit`

## Requirements
- R1: For an operand that is positive and normal (sign bit 31 clear, exponent field in bits 30..23 between 1 and 254, fraction in bits 22..0), the result has sign 0. Its exponent field is E/2 + 127, where E is the even-adjusted unbiased exponent. Its fraction is bits 22..0 of floor(sqrt(S * 2^23)), where S is the adjusted significand.
- R2: If the unbiased exponent (field minus 127) is odd, then S = (2^23 + fraction) * 2 and E = unbiased - 1. For example, 2.25 (0x40100000) gives 1.5 (0x3FC00000).
- R3: If the unbiased exponent is even, then S = 2^23 + fraction and E = unbiased. The exponent is halved by an arithmetic shift. For example, 4.0 gives 2.0 and 16.0 gives 4.0.
- R4: The result fraction is truncated, never rounded up. For example, 3.0 (0x40400000) gives 0x3FDDB3D7.
- R5: An operand whose exponent field is 0 (a zero or a subnormal) gives a zero result that keeps the operand's sign bit: 0x00000000 or 0x80000000.
- R6: Positive infinity (0x7F800000) gives positive infinity.
- R7: A NaN operand (exponent field 255, nonzero fraction, either sign) gives the operand with fraction bit 22 set.
- R8: Any other operand with sign bit 1 (a negative normal, or negative infinity) gives the canonical quiet NaN 0x7FC00000.
- R9: A request is accepted on a clock edge where both reqValid and reqReady are high. reqReady is 1 after reset, and is 0 from the accepting edge until the result cycle has ended.
- R10: rspValid is high for exactly one cycle per accepted request, starting 24 clock edges after the accepting edge. reqValid pulses and operand changes while the unit is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Operand offered |
| reqReady | output | 1 | Unit idle and able to accept |
| reqOperand | input | 32 | binary32 operand |
| rspValid | output | 1 | Result strobe, one cycle |
| rspResult | output | 32 | binary32 square root, valid with rspValid |

## Verification
Every result, special encodings included, is due on the cycle that follows the 24th rising edge after the accepting edge. The bench therefore counts falling edges from the handshake and requires rspValid first on the 25th. Each check is sampled at a falling edge, clear of the registers' update. The bench also samples once more after the result cycle, to confirm the strobe has dropped and reqReady has returned. On every falling edge while the unit is busy, it checks that reqReady stays low. In one run it keeps reqValid high and changes the operand during the busy period, and the result must still belong to the first operand.

// File: rtl/fp32_sqrt_pkg.sv
package fp32_sqrt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sqrtState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic step;
  } sqrtStrobe_t;

endpackage

// File: rtl/fp32_sqrt_root_step.sv
// One non-restoring square-root iteration: consumes a radicand bit pair,
// produces the next partial remainder and one more root bit.
module fp32_sqrt_root_step #(
  parameter int ROOT_W = 24,
  localparam int REM_W = ROOT_W + 3
) (
  input  logic [REM_W-1:0]  remIn,
  input  logic [ROOT_W-1:0] rootIn,
  input  logic [1:0]        bitPair,
  output logic [REM_W-1:0]  remOut,
  output logic [ROOT_W-1:0] rootOut
);

  logic [REM_W-1:0] remShift;
  logic [REM_W-1:0] trialSub;
  logic [REM_W-1:0] trialAdd;

  always_comb begin
    remShift = {remIn[REM_W-3:0], bitPair};
    trialSub = {1'b0, rootIn, 2'b01};
    trialAdd = {1'b0, rootIn, 2'b11};
    if (remIn[REM_W-1]) begin
      remOut = remShift + trialAdd;
    end else begin
      remOut = remShift - trialSub;
    end
    rootOut = {rootIn[ROOT_W-2:0], ~remOut[REM_W-1]};
  end

endmodule

// File: rtl/fp32_sqrt_ctrl.sv
// Sequencer: accepts a request, runs one root step per cycle, raises the
// result strobe for a single cycle.
module fp32_sqrt_ctrl
  import fp32_sqrt_pkg::*;
#(
  parameter int ROOT_W = 24,
  localparam int CNT_W = $clog2(ROOT_W + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        rspValid,
  output sqrtStrobe_t strobe
);

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(ROOT_W - 1);

  sqrtState_t       stateQ;
  sqrtState_t       stateD;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateD      = stateQ;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateD      = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (stepCnt == LAST_STEP) stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (strobe.load)      stepCnt <= '0;
      else if (strobe.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign rspValid = (stateQ == ST_DONE);

endmodule

// File: rtl/fp32_sqrt_datapath.sv
// Unpack, exponent parity fix-up, iterative root, repack and special cases.
module fp32_sqrt_datapath
  import fp32_sqrt_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int ROOT_W = FRAC_W + 1,
  localparam int RAD_W  = 2 * ROOT_W,
  localparam int REM_W  = ROOT_W + 3,
  localparam int UE_W   = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqrtStrobe_t       strobe,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] result
);

  localparam logic [WORD_W-1:0] CANON_QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] POS_INF =
    {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] QUIET_BIT =
    {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // operand fields
  logic              opSign;
  logic [EXP_W-1:0]  opExp;
  logic [FRAC_W-1:0] opFrac;
  logic              expZero;
  logic              expOnes;
  logic              fracZero;

  // exponent path
  logic signed [UE_W-1:0] unbiased;
  logic signed [UE_W-1:0] evenExp;
  logic signed [UE_W-1:0] halfExp;
  logic signed [UE_W-1:0] packedExpWide;
  logic                   oddExp;

  // significand path
  logic [ROOT_W:0]   sigAdj;
  logic [RAD_W-1:0]  radicand;

  // special-case decode
  logic              isSpecial;
  logic [WORD_W-1:0] specialWord;

  always_comb begin
    opSign   = operand[WORD_W-1];
    opExp    = operand[WORD_W-2:FRAC_W];
    opFrac   = operand[FRAC_W-1:0];
    expZero  = (opExp == '0);
    expOnes  = (opExp == '1);
    fracZero = (opFrac == '0);

    unbiased      = $signed({2'b00, opExp}) - $signed(UE_W'(BIAS));
    oddExp        = unbiased[0];
    evenExp       = oddExp ? (unbiased - $signed(UE_W'(1))) : unbiased;
    halfExp       = evenExp >>> 1;
    packedExpWide = halfExp + $signed(UE_W'(BIAS));

    sigAdj   = oddExp ? {1'b1, opFrac, 1'b0} : {2'b01, opFrac};
    radicand = {sigAdj, {FRAC_W{1'b0}}};

    isSpecial   = 1'b1;
    specialWord = '0;
    if (expOnes && !fracZero) begin
      specialWord = operand | QUIET_BIT;          // NaN in, quiet NaN out
    end else if (expZero) begin
      specialWord = {opSign, {(WORD_W-1){1'b0}}}; // zero or flushed subnormal
    end else if (opSign) begin
      specialWord = CANON_QNAN;                   // negative nonzero
    end else if (expOnes) begin
      specialWord = POS_INF;
    end else begin
      isSpecial = 1'b0;
    end
  end

  // registered state
  logic [RAD_W-1:0]  radSr;
  logic [REM_W-1:0]  remQ;
  logic [ROOT_W-1:0] rootQ;
  logic [EXP_W-1:0]  expOutQ;
  logic              specialQ;
  logic [WORD_W-1:0] specialWordQ;

  logic [REM_W-1:0]  remNext;
  logic [ROOT_W-1:0] rootNext;

  fp32_sqrt_root_step #(.ROOT_W(ROOT_W)) u_step (
    .remIn  (remQ),
    .rootIn (rootQ),
    .bitPair(radSr[RAD_W-1 -: 2]),
    .remOut (remNext),
    .rootOut(rootNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      radSr        <= '0;
      remQ         <= '0;
      rootQ        <= '0;
      expOutQ      <= '0;
      specialQ     <= 1'b0;
      specialWordQ <= '0;
    end else if (strobe.load) begin
      radSr        <= radicand;
      remQ         <= '0;
      rootQ        <= '0;
      expOutQ      <= packedExpWide[EXP_W-1:0];
      specialQ     <= isSpecial;
      specialWordQ <= specialWord;
    end else if (strobe.step) begin
      radSr <= {radSr[RAD_W-3:0], 2'b00};
      remQ  <= remNext;
      rootQ <= rootNext;
    end
  end

  assign result = specialQ ? specialWordQ
                           : {1'b0, expOutQ, rootQ[FRAC_W-1:0]};

endmodule

// File: rtl/fp32_sqrt_unit.sv
module fp32_sqrt_unit
  import fp32_sqrt_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int ROOT_W = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [WORD_W-1:0] reqOperand,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspResult
);

  sqrtStrobe_t strobe;

  fp32_sqrt_ctrl #(.ROOT_W(ROOT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .strobe  (strobe)
  );

  fp32_sqrt_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .operand(reqOperand),
    .result (rspResult)
  );

endmodule

// File: rtl/fp32_sqrt_unit_chk.sv
module fp32_sqrt_unit_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int ROOT_W = FRAC_W + 1,
  localparam int CNT_W  = $clog2(ROOT_W + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [WORD_W-1:0] reqOperand,
  input logic              rspValid,
  input logic [WORD_W-1:0] rspResult
);

  logic [WORD_W-1:0] heldOp;
  logic [CNT_W-1:0]  busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldOp  <= '0;
      busyCnt <= '0;
    end else if (reqValid && reqReady) begin
      heldOp  <= reqOperand;
      busyCnt <= '0;
    end else if (!reqReady && busyCnt != '1) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  logic             heldSign;
  logic [EXP_W-1:0] heldExp;
  logic             heldNan;
  assign heldSign = heldOp[WORD_W-1];
  assign heldExp  = heldOp[WORD_W-2:FRAC_W];
  assign heldNan  = (heldExp == '1) && (heldOp[FRAC_W-1:0] != '0);

  // R9: accepting a request drops ready on the next cycle
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9: ready is low during the result cycle
  p_not_ready_on_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R10: strobe lasts one cycle, then the unit is idle
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R10: fixed latency counted from the accepting edge
  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (busyCnt == CNT_W'(ROOT_W)));

  // R5: zero exponent field returns a signed zero
  p_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && heldExp == '0) |-> (rspResult == {heldSign, {(WORD_W-1){1'b0}}}));

  // R8: negative nonzero non-NaN operand returns the canonical quiet NaN
  p_neg_qnan_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && heldSign && heldExp != '0 && !heldNan)
      |-> (rspResult == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));

  // R1: positive normal operand gives a positive normal result
  p_normal_positive_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !heldSign && heldExp != '0 && heldExp != '1)
      |-> (!rspResult[WORD_W-1] && rspResult[WORD_W-2:FRAC_W] != '0
           && rspResult[WORD_W-2:FRAC_W] != '1));

endmodule

bind fp32_sqrt_unit fp32_sqrt_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqOperand(reqOperand),
  .rspValid  (rspValid),
  .rspResult (rspResult)
);

// File: tb/fp32_sqrt_unit_bench.sv
`timescale 1ns/1ps
module fp32_sqrt_unit_bench;

  localparam int LAT_NEG = 25;   // falling edges from accept to first strobe sample

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqOperand = '0;
  logic        rspValid;
  logic [31:0] rspResult;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  fp32_sqrt_unit u_fp32_sqrt_unit (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOperand(reqOperand),
    .rspValid(rspValid), .rspResult(rspResult)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic longint unsigned isqrtRef(input longint unsigned v);
    longint unsigned r = 0;
    for (int b = 23; b >= 0; b--) begin
      longint unsigned t = r | (64'd1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  function automatic logic [31:0] modelSqrt(input logic [31:0] op);
    logic [7:0]  e = op[30:23];
    logic [22:0] f = op[22:0];
    int ue;
    longint unsigned sig, root;
    logic [7:0] eo;
    if (e == 8'hFF && f != 0) return op | 32'h0040_0000;
    if (e == 8'h00)           return {op[31], 31'b0};
    if (op[31])               return 32'h7FC0_0000;
    if (e == 8'hFF)           return 32'h7F80_0000;
    ue  = int'(e) - 127;
    sig = (64'd1 << 23) | longint'(f);
    if ((ue & 1) != 0) begin
      sig = sig << 1;
      ue  = ue - 1;
    end
    root = isqrtRef(sig << 23);
    eo   = 8'(ue / 2 + 127);
    return {1'b0, eo, root[22:0]};
  endfunction

  function automatic string tagFor(input logic [31:0] op);
    int ue = int'(op[30:23]) - 127;
    if (op[30:23] == 8'hFF && op[22:0] != 0) return "R7 nan";
    if (op[30:23] == 8'h00) return "R5 zero";
    if (op[31]) return "R8 negative";
    if (op[30:23] == 8'hFF) return "R6 inf";
    return ((ue & 1) != 0) ? "R1/R2 odd-exp" : "R1/R3 even-exp";
  endfunction

  task automatic runOne(input logic [31:0] op, input string tag, input bit noise);
    int  n = 0;
    bit  readyLeak = 0;
    logic [31:0] exp = modelSqrt(op);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqOperand = op;
    reqValid   = 1'b1;
    @(posedge clk);
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (noise && n < 10) begin
        reqOperand = ~op;
        reqValid   = 1'b1;
      end else begin
        reqValid   = 1'b0;
        reqOperand = 32'hDEAD_BEEF;
      end
      if (rspValid) break;
      if (reqReady) readyLeak = 1;
    end
    check(!readyLeak, "R9 ready low while busy", {31'b0, readyLeak}, 32'd0);
    check(n == LAT_NEG, "R10 latency", n, LAT_NEG);
    check(rspResult === exp, tag, rspResult, exp);
    @(negedge clk);
    check(!rspValid && reqReady, "R10 single strobe then idle",
          {30'b0, rspValid, reqReady}, 32'd1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check(reqReady === 1'b1, "R9 reset ready", {31'b0, reqReady}, 32'd1);
    check(rspValid === 1'b0, "R10 reset strobe", {31'b0, rspValid}, 32'd0);
    rstN = 1'b1;

    runOne(32'h4080_0000, "R3 4.0", 0);
    check(modelSqrt(32'h4080_0000) == 32'h4000_0000, "R3 model 4.0",
          modelSqrt(32'h4080_0000), 32'h4000_0000);
    runOne(32'h4010_0000, "R2 2.25", 0);
    check(modelSqrt(32'h4010_0000) == 32'h3FC0_0000, "R2 model 2.25",
          modelSqrt(32'h4010_0000), 32'h3FC0_0000);
    runOne(32'h4180_0000, "R3 16.0", 0);
    runOne(32'h3E80_0000, "R3 0.25", 0);
    runOne(32'h3F00_0000, "R2 0.5", 0);
    runOne(32'h4000_0000, "R2 2.0", 0);
    runOne(32'h4040_0000, "R4 truncated 3.0", 0);
    check(modelSqrt(32'h4040_0000) == 32'h3FDD_B3D7, "R4 model 3.0",
          modelSqrt(32'h4040_0000), 32'h3FDD_B3D7);
    runOne(32'h7F7F_FFFF, "R1 largest", 0);
    runOne(32'h0080_0000, "R1 smallest normal", 0);
    runOne(32'h0000_0000, "R5 +0", 0);
    runOne(32'h8000_0000, "R5 -0", 0);
    runOne(32'h0000_0001, "R5 +subnormal", 0);
    runOne(32'h8040_0000, "R5 -subnormal", 0);
    runOne(32'h7F80_0000, "R6 +inf", 0);
    runOne(32'hFF80_0000, "R8 -inf", 0);
    runOne(32'hC080_0000, "R8 -4.0", 0);
    runOne(32'h7F80_0001, "R7 signalling nan", 0);
    runOne(32'hFFA0_0000, "R7 negative nan", 0);
    runOne(32'h4110_0000, "R10 busy requests ignored 9.0", 1);

    for (int i = 0; i < 80; i++) begin
      logic [31:0] op;
      int cls = int'($urandom % 8);
      op[22:0] = 23'($urandom);
      case (cls)
        5:       begin op[31] = 1'b1; op[30:23] = 8'(1 + $urandom % 254); end
        6:       begin op[31] = 1'($urandom); op[30:23] = 8'hFF; op[0] = 1'b1; end
        7:       begin op[31] = 1'($urandom); op[30:23] = 8'h00; end
        default: begin op[31] = 1'b0; op[30:23] = 8'(1 + $urandom % 254); end
      endcase
      runOne(op, tagFor(op), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule